// File: doc/BRIEF.md
# Paged Memory Address Mapper

This block sits on a 16-bit CPU address bus in front of a large SRAM. It widens each logical address into a physical one. The logical space is split into sixteen 4 KiB regions, and each region has its own page register. In mapped mode, the page held by the register for the accessed region replaces the region number in the physical address. The low twelve address bits pass through unchanged. In pass-through mode, which is the state after reset, the physical address is simply the logical address. In that mode the block behaves like an ordinary 32K RAM expansion.

A serial-bit control port carries two single-bit controls. The access control opens a register window at 0x4000–0x401F. While the window is open, the peripheral ROM that normally lives there is disabled. Software can then write or read any page register as a 16-bit word, with the page number in the upper byte. The mode control chooses between mapped and pass-through translation. Only the regions 0x2000–0x3FFF and 0xA000–0xFFFF select the RAM. The registers of all other regions still store their values and read them back.

Top module: `pageMapper`

## Requirements
- R1: A synchronous active-high reset clears both control bits: the block is in pass-through mode and the ROM-disable output is low.
- R2: A control write (ctlWrite high) with ctlBit 0 loads the access control and with ctlBit 1 loads the mode control (1 = mapped), both from ctlValue on the next clock edge. romDisable follows the access control.
- R3: In pass-through mode ramAddr equals the logical address, zero-extended to the physical width.
- R4: In mapped mode ramAddr is {page register selected by cpuAddr[15:12], cpuAddr[11:0]}. For example, with register 0xA holding 0x15, logical 0xA02E gives physical 0x1502E.
- R5: ramSelect is high only during a read or write strobe whose address lies in regions 0x2, 0x3 or 0xA–0xF.
- R6: With the access control set, a write to 0x4000 + 2·n stores bits [15:8] of the data word into register n. Address bits [4:1] select n, and the low data byte is ignored.
- R7: With the access control set, a read inside the window returns {page, 8'h00} for the addressed register. readData is zero for every other access.
- R8: With the access control clear, writes to the window addresses leave the page registers unchanged.
- R9: Registers of regions that never select the RAM still store and read back their pages.
- R10: Two regions whose registers hold the same page reach the same RAM word. Data written through one is read back through the other.
- R11: A register write is used by the very next bus access after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctlWrite | input | 1 | Control-bit write strobe from the serial-bit port |
| ctlBit | input | 1 | Control bit index: 0 = register access, 1 = mapped mode |
| ctlValue | input | 1 | Value written to the selected control bit |
| cpuAddr | input | 16 | Logical CPU address |
| cpuDataIn | input | 16 | CPU write data |
| cpuRead | input | 1 | CPU read strobe |
| cpuWrite | input | 1 | CPU write strobe |
| ramAddr | output | PAGE_BITS+12 | Physical RAM address |
| ramSelect | output | 1 | RAM chip select |
| romDisable | output | 1 | Disables the peripheral ROM while the register window is open |
| readData | output | 16 | Register read-back data |

## Verification
A wrong page register shows up in two places. It appears on ramAddr at the first mapped access to its region, and it appears on readData at the first window read of that register. Both are seen in the same cycle as the access. A control bit stuck at the wrong value shows at once, either on romDisable or as a ramAddr that differs from the logical address. The reference model predicts ramAddr, ramSelect, romDisable and readData on every cycle. So any divergence is reported at the first access that exposes it, including the access immediately after a register write. The aliasing check goes through a modelled RAM. This catches a translation that looks plausible but sends two regions to different words.

// File: rtl/pageMapPkg.sv
package pageMapPkg;
  localparam int REG_SEL_W = 4;
  localparam int NUM_REGS  = 1 << REG_SEL_W;

  typedef struct packed {
    logic                 mapAccess;
    logic                 mapMode;
    logic                 regWrite;
    logic                 regRead;
    logic [REG_SEL_W-1:0] regIndex;
  } mapCtl_t;
endpackage

// File: rtl/pageMapCtl.sv
module pageMapCtl
  import pageMapPkg::*;
#(
  parameter logic [15:0] WIN_BASE = 16'h4000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        ctlWrite,
  input  logic        ctlBit,
  input  logic        ctlValue,
  input  logic [15:0] cpuAddr,
  input  logic        cpuRead,
  input  logic        cpuWrite,
  output mapCtl_t     ctl
);
  localparam int WIN_LSB = REG_SEL_W + 1;

  logic accessBit;
  logic modeBit;
  logic winHit;

  always_ff @(posedge clk) begin
    if (rst) begin
      accessBit <= 1'b0;
      modeBit   <= 1'b0;
    end else if (ctlWrite) begin
      if (ctlBit) modeBit   <= ctlValue;
      else        accessBit <= ctlValue;
    end
  end

  assign winHit = (cpuAddr[15:WIN_LSB] == WIN_BASE[15:WIN_LSB]);

  always_comb begin
    ctl.mapAccess = accessBit;
    ctl.mapMode   = modeBit;
    ctl.regWrite  = accessBit & winHit & cpuWrite;
    ctl.regRead   = accessBit & winHit & cpuRead;
    ctl.regIndex  = cpuAddr[WIN_LSB-1:1];
  end

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (!ctl.mapAccess && !ctl.mapMode));

  assert_mode_load_R2: assert property (@(posedge clk) disable iff (rst)
    (ctlWrite && ctlBit) |=> (ctl.mapMode == $past(ctlValue)));

  assert_access_load_R2: assert property (@(posedge clk) disable iff (rst)
    (ctlWrite && !ctlBit) |=> (ctl.mapAccess == $past(ctlValue)));

  assert_ctl_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !ctlWrite |=> ($stable(ctl.mapAccess) && $stable(ctl.mapMode)));

  assert_window_closed_R8: assert property (@(posedge clk) disable iff (rst)
    !ctl.mapAccess |-> (!ctl.regWrite && !ctl.regRead));
endmodule

// File: rtl/pageMapData.sv
module pageMapData
  import pageMapPkg::*;
#(
  parameter int PAGE_BITS = 8,
  parameter logic [NUM_REGS-1:0] RAM_REGIONS = 16'hFC0C,
  localparam int PHYS_W = PAGE_BITS + 12
) (
  input  logic              clk,
  input  logic              rst,
  input  mapCtl_t           ctl,
  input  logic [15:0]       cpuAddr,
  input  logic [15:0]       cpuDataIn,
  input  logic              cpuRead,
  input  logic              cpuWrite,
  output logic [PHYS_W-1:0] ramAddr,
  output logic              ramSelect,
  output logic [15:0]       readData
);
  logic [PAGE_BITS-1:0] pageReg [NUM_REGS];
  logic [PAGE_BITS-1:0] selPage;
  logic [PAGE_BITS-1:0] rdPage;
  logic [REG_SEL_W-1:0] region;

  genvar g;
  generate
    for (g = 0; g < NUM_REGS; g++) begin : gPageReg
      always_ff @(posedge clk) begin
        if (ctl.regWrite && (ctl.regIndex == REG_SEL_W'(g)))
          pageReg[g] <= cpuDataIn[8 +: PAGE_BITS];
      end
    end
  endgenerate

  assign region    = cpuAddr[15:12];
  assign selPage   = pageReg[region];
  assign rdPage    = pageReg[ctl.regIndex];
  assign ramSelect = (cpuRead | cpuWrite) & RAM_REGIONS[region];

  always_comb begin
    if (ctl.mapMode) ramAddr = {selPage, cpuAddr[11:0]};
    else             ramAddr = PHYS_W'(cpuAddr);
  end

  assign readData = ctl.regRead ? {8'(rdPage), 8'h00} : 16'h0000;

  assert_reg_store_R6: assert property (@(posedge clk) disable iff (rst)
    ctl.regWrite |=> (pageReg[$past(ctl.regIndex)] == $past(cpuDataIn[8 +: PAGE_BITS])));

  assert_offset_kept_R4: assert property (@(posedge clk) disable iff (rst)
    ramSelect |-> (ramAddr[11:0] == cpuAddr[11:0]));

  assert_no_ram_in_window_R5: assert property (@(posedge clk) disable iff (rst)
    ctl.regWrite |-> !ramSelect);

  assert_readback_low_zero_R7: assert property (@(posedge clk) disable iff (rst)
    ctl.regRead |-> (readData[7:0] == 8'h00));
endmodule

// File: rtl/pageMapper.sv
module pageMapper
  import pageMapPkg::*;
#(
  parameter int PAGE_BITS = 8,
  localparam int PHYS_W = PAGE_BITS + 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctlWrite,
  input  logic              ctlBit,
  input  logic              ctlValue,
  input  logic [15:0]       cpuAddr,
  input  logic [15:0]       cpuDataIn,
  input  logic              cpuRead,
  input  logic              cpuWrite,
  output logic [PHYS_W-1:0] ramAddr,
  output logic              ramSelect,
  output logic              romDisable,
  output logic [15:0]       readData
);
  mapCtl_t ctl;

  pageMapCtl #(.WIN_BASE(16'h4000)) uCtl (
    .clk(clk), .rst(rst), .ctlWrite(ctlWrite), .ctlBit(ctlBit),
    .ctlValue(ctlValue), .cpuAddr(cpuAddr), .cpuRead(cpuRead),
    .cpuWrite(cpuWrite), .ctl(ctl)
  );

  pageMapData #(.PAGE_BITS(PAGE_BITS), .RAM_REGIONS(16'hFC0C)) uData (
    .clk(clk), .rst(rst), .ctl(ctl), .cpuAddr(cpuAddr),
    .cpuDataIn(cpuDataIn), .cpuRead(cpuRead), .cpuWrite(cpuWrite),
    .ramAddr(ramAddr), .ramSelect(ramSelect), .readData(readData)
  );

  assign romDisable = ctl.mapAccess;
endmodule

// File: tb/sim_pageMapper.sv
module sim_pageMapper;
  logic        clk = 1'b0;
  logic        rst, ctlWrite, ctlBit, ctlValue, cpuRead, cpuWrite;
  logic [15:0] cpuAddr, cpuDataIn;
  logic [19:0] ramAddr;
  logic        ramSelect, romDisable;
  logic [15:0] readData;

  int vectors = 0;
  int misses  = 0;
  bit done    = 0;

  bit          mAcc, mMap;
  int          mRegs [16];
  bit          mValid [16];
  logic [15:0] mem [int];

  always #2 clk = ~clk;

  pageMapper u0 (
    .clk(clk), .rst(rst), .ctlWrite(ctlWrite), .ctlBit(ctlBit),
    .ctlValue(ctlValue), .cpuAddr(cpuAddr), .cpuDataIn(cpuDataIn),
    .cpuRead(cpuRead), .cpuWrite(cpuWrite), .ramAddr(ramAddr),
    .ramSelect(ramSelect), .romDisable(romDisable), .readData(readData)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic bit inRam(input logic [15:0] a);
    int r = a >> 12;
    return (r == 2) || (r == 3) || (r >= 10);
  endfunction

  function automatic bit inWin(input logic [15:0] a);
    return (a >= 16'h4000) && (a <= 16'h401F);
  endfunction

  task automatic step(input bit r, input bit cw, input bit cb, input bit cv,
                      input bit rd, input bit wr, input logic [15:0] a,
                      input logic [15:0] d, input string tag);
    int expAddr;
    int idx;
    logic [19:0] sampAddr;
    bit sampSel;
    @(negedge clk);
    rst = r; ctlWrite = cw; ctlBit = cb; ctlValue = cv;
    cpuRead = rd; cpuWrite = wr; cpuAddr = a; cpuDataIn = d;
    #1;
    if (!r) begin
      chk("R2 romDisable", romDisable, mAcc);
      chk("R5 ramSelect", ramSelect, (rd || wr) && inRam(a));
      if (!mMap) chk("R3 passAddr", ramAddr, a);
      else if (mValid[a >> 12]) begin
        expAddr = (mRegs[a >> 12] << 12) | (a & 16'h0FFF);
        chk((tag == "R11") ? "R11 mappedAddr" : "R4 mappedAddr", ramAddr, expAddr);
      end
      idx = (a >> 1) & 15;
      if (mAcc && rd && inWin(a)) chk(tag, readData, mRegs[idx] << 8);
      else chk("R7 readIdle", readData, 0);
      if (tag == "R10" && rd && ramSelect) begin
        if (mem.exists(int'(ramAddr))) chk("R10 alias", mem[int'(ramAddr)], d);
        else chk("R10 alias", 32'hDEAD, d);
      end
    end
    sampAddr = ramAddr;
    sampSel  = ramSelect;
    @(posedge clk);
    if (r) begin
      mAcc = 0; mMap = 0;
    end else begin
      if (mAcc && wr && inWin(a)) begin
        idx = (a >> 1) & 15;
        mRegs[idx] = d[15:8];
        mValid[idx] = 1;
      end
      if (cw) begin
        if (cb) mMap = cv; else mAcc = cv;
      end
      if (sampSel && wr) mem[int'(sampAddr)] = d;
    end
  endtask

  task automatic idle(input logic [15:0] a, input string tag);
    step(0, 0, 0, 0, 0, 0, a, 16'h0, tag);
  endtask

  initial begin
    #400000;
    if (!done) begin
      misses++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) begin mRegs[i] = 0; mValid[i] = 0; end
    mAcc = 0; mMap = 0;
    step(1, 0, 0, 0, 0, 0, 16'h0, 16'h0, "R1");
    step(1, 0, 0, 0, 0, 0, 16'h0, 16'h0, "R1");
    @(negedge clk);
    rst = 0; cpuRead = 1; cpuAddr = 16'hA02E; ctlWrite = 0; cpuWrite = 0;
    #1;
    chk("R1 romDisable after reset", romDisable, 0);
    chk("R1 pass mode after reset", ramAddr, 20'h0A02E);
    // R3 / R5: pass-through accesses in several regions
    step(0, 0, 0, 0, 1, 0, 16'h2345, 16'h0, "R7");
    step(0, 0, 0, 0, 0, 1, 16'hA02E, 16'h1234, "R7");
    step(0, 0, 0, 0, 1, 0, 16'h4000, 16'h0, "R7");
    step(0, 0, 0, 0, 1, 0, 16'h8000, 16'h0, "R7");
    step(0, 0, 0, 0, 1, 0, 16'hFFFE, 16'h0, "R7");
    // R2: open the register window
    step(0, 1, 0, 1, 0, 0, 16'h0, 16'h0, "R2");
    // R6: load all registers, low byte is junk
    for (int n = 0; n < 16; n++)
      step(0, 0, 0, 0, 0, 1, 16'h4000 + 16'(2 * n),
           {8'((n * 17 + 3) & 255), 8'hAB}, "R6");
    // R7 / R9: read back every register
    for (int n = 0; n < 16; n++)
      step(0, 0, 0, 0, 1, 0, 16'h4000 + 16'(2 * n), 16'h0,
           inRam(16'(n << 12)) ? "R7" : "R9");
    step(0, 0, 0, 0, 1, 0, 16'h4020, 16'h0, "R7");
    // R2: enter mapped mode with the window still open
    step(0, 1, 1, 1, 0, 0, 16'h0, 16'h0, "R2");
    // R11: register 0xA gets page 0x15, next access uses it (R4 example)
    step(0, 0, 0, 0, 0, 1, 16'h4014, 16'h15CD, "R6");
    step(0, 0, 0, 0, 0, 1, 16'hA02E, 16'h5555, "R11");
    step(0, 0, 0, 0, 1, 0, 16'hFFFF, 16'h0, "R7");
    step(0, 0, 0, 0, 1, 0, 16'h2ABC, 16'h0, "R7");
    // R8: close window, write to window address must not store
    step(0, 1, 0, 0, 0, 0, 16'h0, 16'h0, "R2");
    step(0, 0, 0, 0, 0, 1, 16'h4014, 16'h7700, "R8");
    step(0, 1, 0, 1, 0, 0, 16'h0, 16'h0, "R2");
    step(0, 0, 0, 0, 1, 0, 16'h4014, 16'h0, "R8");
    // R10: region 0xB also gets page 0x15
    step(0, 0, 0, 0, 0, 1, 16'h4016, 16'h1500, "R6");
    step(0, 1, 0, 0, 0, 0, 16'h0, 16'h0, "R2");
    step(0, 0, 0, 0, 0, 1, 16'hA010, 16'hBEEF, "R4");
    step(0, 0, 0, 0, 1, 0, 16'hB010, 16'hBEEF, "R10");
    step(0, 0, 0, 0, 0, 1, 16'hB7F2, 16'hCAFE, "R4");
    step(0, 0, 0, 0, 1, 0, 16'hA7F2, 16'hCAFE, "R10");
    // R3: back to pass-through
    step(0, 1, 1, 0, 0, 0, 16'h0, 16'h0, "R2");
    step(0, 0, 0, 0, 1, 0, 16'hA02E, 16'h0, "R7");
    idle(16'h3000, "R7");
    // R1: reset mid-run clears the controls
    step(0, 1, 0, 1, 0, 0, 16'h0, 16'h0, "R2");
    step(0, 1, 1, 1, 0, 0, 16'h0, 16'h0, "R2");
    step(1, 0, 0, 0, 0, 0, 16'h0, 16'h0, "R1");
    @(negedge clk);
    rst = 0; cpuRead = 1; cpuAddr = 16'hC123;
    #1;
    chk("R1 romDisable after reset", romDisable, 0);
    chk("R1 pass mode after reset", ramAddr, 20'h0C123);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule